// File: doc/BRIEF.md
# Shared-Line Pad Event Aggregator

This block watches a bank of pad input levels and turns their activity into interrupt requests. Each pad has a trigger code, an inversion bit and a line select. The trigger code picks falling edges, rising edges, both edges or an active level. The line select steers the pad's events onto one of sixteen shared interrupt lines. Several pads may share one line, and their events are ORed together.

Each line has a sticky pending bit in a status register and an enable bit in a mask register. Both registers sit on a simple register bus. Software clears a pending bit by writing a one to it. A single interrupt output stays high while any pending line is also enabled. Software reads the status register and services the lowest set line first.

The pad levels are assumed to be synchronised already. The per-pad configuration is held outside this block and arrives on flat input vectors.

Top module: `padirq_fold_top`

## Requirements
- R1: After a synchronous reset, the status register, the mask register, the read data and the interrupt output are all zero.
- R2: Trigger code 1 (falling) sets the pending bit of the selected line at the clock edge that follows a 1-to-0 change of the pad level after inversion. A 0-to-1 change sets nothing.
- R3: Trigger code 2 (rising) sets the selected line's pending bit on a 0-to-1 change of the pad level after inversion.
- R4: Trigger code 3 sets the selected line's pending bit on any change of the pad level after inversion.
- R5: Trigger code 4 (level) sets the selected line's pending bit at every clock edge while the pad level after inversion is 1. The active level is therefore high with inversion clear and low with inversion set. The bit is set again at the very edge where it is cleared if the level is still active.
- R6: Trigger code 0 and the unused codes 5, 6 and 7 never set any pending bit.
- R7: Each pad's 4-bit select value N routes its events to line N only. Events from several pads on one line set that single bit.
- R8: The status register is at byte offset 0x300 and holds lines 0 to 15 in bits 0 to 15. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. If an event hits the same bit at the same edge as a clear, the bit stays set.
- R9: The mask register at byte offset 0x380 is written and read in bits 0 to 15. A 1 enables the line. Pending bits are captured whatever the mask holds.
- R10: The interrupt output is 1 exactly when (status AND mask) is non-zero. It changes at the same clock edge as the registers it depends on.
- R11: A read returns data on reg_rdata one clock after the read strobe, zero-extended above bit 15. The read data holds its value when no read is made. Reads of any other offset return 0, and writes to any other offset change nothing.
- R12: A pad level that is held steady through reset produces no edge event after reset is released.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_level | input | NUM_PADS | Synchronised pad input levels |
| pad_inv | input | NUM_PADS | Per-pad inversion applied before detection |
| pad_trig | input | 3*NUM_PADS | Per-pad 3-bit trigger code |
| pad_sel | input | SEL_W*NUM_PADS | Per-pad shared line select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with six pads and the default sixteen lines. With fewer pads than lines, several pads are pushed onto one line while most lines stay idle. The select field still reaches the extreme lines 0 and 15. Random reconfiguration with all eight trigger codes and both inversion settings reaches the unused codes, level re-arming against clears, and collisions of an event with a clear in the same cycle. These cases are compared cycle by cycle against a reference model kept in the bench.

// File: rtl/padirq_pkg.sv
package padirq_pkg;
  localparam int TRIG_W = 3;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF   = 3'd0,
    TRIG_FALL  = 3'd1,
    TRIG_RISE  = 3'd2,
    TRIG_BOTH  = 3'd3,
    TRIG_LEVEL = 3'd4
  } trig_e;
endpackage

// File: rtl/padirq_event_det.sv
module padirq_event_det
  import padirq_pkg::*;
#(
  parameter int NUM_PADS = 8
) (
  input  logic                       clk,
  input  logic [NUM_PADS-1:0]        level,
  input  logic [NUM_PADS-1:0]        inv,
  input  logic [TRIG_W*NUM_PADS-1:0] trig,
  output logic [NUM_PADS-1:0]        evt
);
  logic [NUM_PADS-1:0] cur;
  logic [NUM_PADS-1:0] prev_q;

  assign cur = level ^ inv;

  // Previous level is loaded every cycle, reset included, so a level that is
  // held steady through reset shows no edge afterwards.
  always_ff @(posedge clk) prev_q <= cur;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    trig_e mode;
    assign mode = trig_e'(trig[p*TRIG_W +: TRIG_W]);
    always_comb begin
      case (mode)
        TRIG_FALL:  evt[p] = prev_q[p] & ~cur[p];
        TRIG_RISE:  evt[p] = ~prev_q[p] & cur[p];
        TRIG_BOTH:  evt[p] = prev_q[p] ^ cur[p];
        TRIG_LEVEL: evt[p] = cur[p];
        default:    evt[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/padirq_line_fold.sv
module padirq_line_fold #(
  parameter int NUM_PADS  = 8,
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_PADS-1:0]       pad_evt,
  input  logic [SEL_W*NUM_PADS-1:0] pad_sel,
  output logic [NUM_LINES-1:0]      line_evt
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_PADS-1:0] hit;
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      assign hit[p] = pad_evt[p] && (pad_sel[p*SEL_W +: SEL_W] == SEL_W'(l));
    end
    assign line_evt[l] = |hit;
  end
endmodule

// File: rtl/padirq_regs.sv
module padirq_regs #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter logic [ADDR_W-1:0] STAT_OFF = 12'h300,
  parameter logic [ADDR_W-1:0] MASK_OFF = 12'h380
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_evt,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_out
);
  logic [NUM_LINES-1:0] status_q, mask_q, status_d, mask_d, clr;
  logic                 stat_hit, mask_hit;
  logic                 unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_LINES];
  assign stat_hit = reg_addr == STAT_OFF;
  assign mask_hit = reg_addr == MASK_OFF;
  assign clr      = (reg_wr && stat_hit) ? reg_wdata[NUM_LINES-1:0] : '0;

  // A new event outranks a clear aimed at the same bit.
  assign status_d = (status_q & ~clr) | line_evt;
  assign mask_d   = (reg_wr && mask_hit) ? reg_wdata[NUM_LINES-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= '0;
      mask_q    <= '0;
      irq_out   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_out  <= |(status_d & mask_d);
      if (reg_rd) begin
        if (stat_hit)      reg_rdata <= DATA_W'(status_q);
        else if (mask_hit) reg_rdata <= DATA_W'(mask_q);
        else               reg_rdata <= '0;
      end
    end
  end

  // R8: a pending bit not cleared stays pending
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (($past(status_q) & ~$past(clr) & ~status_q) == '0));
  // R8: an event wins over a clear in the same cycle
  assert_evt_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (($past(line_evt) & ~status_q) == '0));
  // R7: a bit only becomes pending through its own line's event
  assert_set_by_line_R7: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q) & ~$past(line_evt)) == '0));
  // R9: mask only moves on a write to its offset
  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_wr && mask_hit) |-> $stable(mask_q));
  // R10: combined output follows pending-and-enabled
  assert_irq_match_R10: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(status_q & mask_q));
endmodule

// File: rtl/padirq_fold_top.sv
module padirq_fold_top
  import padirq_pkg::*;
#(
  parameter int NUM_PADS  = 8,
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = $clog2(NUM_LINES),
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PADS-1:0]        pad_level,
  input  logic [NUM_PADS-1:0]        pad_inv,
  input  logic [TRIG_W*NUM_PADS-1:0] pad_trig,
  input  logic [SEL_W*NUM_PADS-1:0]  pad_sel,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic                       irq_out
);
  logic [NUM_PADS-1:0]  pad_evt;
  logic [NUM_LINES-1:0] line_evt;

  padirq_event_det #(.NUM_PADS(NUM_PADS)) u_det (
    .clk  (clk),
    .level(pad_level),
    .inv  (pad_inv),
    .trig (pad_trig),
    .evt  (pad_evt)
  );

  padirq_line_fold #(
    .NUM_PADS (NUM_PADS),
    .NUM_LINES(NUM_LINES),
    .SEL_W    (SEL_W)
  ) u_fold (
    .pad_evt (pad_evt),
    .pad_sel (pad_sel),
    .line_evt(line_evt)
  );

  padirq_regs #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .line_evt (line_evt),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_out  (irq_out)
  );
endmodule

// File: tb/sim_padirq_fold_top.sv
`timescale 1ns/1ps
module sim_padirq_fold_top;
  localparam int NP = 6;
  localparam int NL = 16;
  localparam int SW = 4;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_STAT = 12'h300;
  localparam logic [AW-1:0] A_MASK = 12'h380;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    pad_level = '0;
  logic [NP-1:0]    pad_inv = '0;
  logic [3*NP-1:0]  pad_trig = '0;
  logic [SW*NP-1:0] pad_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq_out;

  always #5 clk = ~clk;

  padirq_fold_top #(.NUM_PADS(NP), .NUM_LINES(NL), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .pad_level(pad_level), .pad_inv(pad_inv),
    .pad_trig(pad_trig), .pad_sel(pad_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  int checks = 0;
  int fails = 0;

  // reference model state
  bit [NP-1:0] m_prev;
  bit [15:0]   m_stat, m_mask;
  bit [31:0]   m_rdata;
  bit          m_irq;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit [15:0] line_events();
    bit [15:0] ev = '0;
    for (int p = 0; p < NP; p++) begin
      bit c = pad_level[p] ^ pad_inv[p];
      bit e;
      case (pad_trig[p*3 +: 3])
        3'd1: e = m_prev[p] & ~c;
        3'd2: e = ~m_prev[p] & c;
        3'd3: e = m_prev[p] ^ c;
        3'd4: e = c;
        default: e = 1'b0;
      endcase
      if (e) ev[pad_sel[p*SW +: SW]] = 1'b1;
    end
    return ev;
  endfunction

  // One clock: compute next model state, step the design, compare at negedge.
  task automatic tick();
    bit [15:0] ev, clr, ns, nm;
    bit [31:0] nr;
    ev  = line_events();
    clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[15:0] : 16'h0;
    ns  = (m_stat & ~clr) | ev;
    nm  = (reg_wr && reg_addr == A_MASK) ? reg_wdata[15:0] : m_mask;
    nr  = m_rdata;
    if (reg_rd) nr = (reg_addr == A_STAT) ? {16'h0, m_stat} :
                     (reg_addr == A_MASK) ? {16'h0, m_mask} : 32'h0;
    @(posedge clk);
    m_prev = pad_level ^ pad_inv;
    if (rst) begin
      m_stat = '0; m_mask = '0; m_rdata = '0; m_irq = 1'b0;
    end else begin
      m_stat = ns; m_mask = nm; m_rdata = nr; m_irq = |(ns & nm);
    end
    @(negedge clk);
    chk("R10 irq_out vs model", {31'h0, irq_out}, {31'h0, m_irq});
    chk("R11 reg_rdata vs model", reg_rdata, m_rdata);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [AW-1:0] a, logic [31:0] exp);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic set_pad(int p, logic [2:0] t, logic iv, logic [3:0] s);
    pad_trig[p*3 +: 3] = t;
    pad_inv[p]         = iv;
    pad_sel[p*SW +: SW] = s;
  endtask

  task automatic lvl(int p, logic v);
    pad_level[p] = v;
    tick();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_prev = '0; m_stat = '0; m_mask = '0; m_rdata = '0; m_irq = 1'b0;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    rd_chk("R1 status after reset", A_STAT, 32'h0);
    rd_chk("R1 mask after reset", A_MASK, 32'h0);

    // R9 mask readback
    wr(A_MASK, 32'hFFFF_FFFF);
    rd_chk("R9 mask readback zero-extended", A_MASK, 32'h0000_FFFF);

    // R3 rising edge, line 5
    set_pad(0, 3'd2, 1'b0, 4'd5); tick();
    lvl(0, 1'b1);
    chk("R10 irq on pending enabled line", {31'h0, irq_out}, 32'h1);
    rd_chk("R3 rising sets line 5", A_STAT, 32'h0020);
    wr(A_STAT, 32'h0020);
    chk("R8 irq drops after clear", {31'h0, irq_out}, 32'h0);
    rd_chk("R8 status cleared", A_STAT, 32'h0);

    // R2 falling edge, line 0
    set_pad(1, 3'd1, 1'b0, 4'd0); tick();
    lvl(1, 1'b1);
    rd_chk("R2 rising ignored in falling mode", A_STAT, 32'h0);
    lvl(1, 1'b0);
    rd_chk("R2 falling sets line 0", A_STAT, 32'h0001);
    wr(A_STAT, 32'h0001);

    // R4 both edges, line 15
    set_pad(2, 3'd3, 1'b0, 4'd15); tick();
    lvl(2, 1'b1);
    rd_chk("R4 rise sets line 15", A_STAT, 32'h8000);
    wr(A_STAT, 32'h8000);
    lvl(2, 1'b0);
    rd_chk("R4 fall sets line 15", A_STAT, 32'h8000);
    wr(A_STAT, 32'h8000);

    // R6 off and unused codes
    set_pad(4, 3'd0, 1'b0, 4'd7); tick();
    lvl(4, 1'b1); lvl(4, 1'b0);
    set_pad(4, 3'd6, 1'b0, 4'd7); tick();
    lvl(4, 1'b1); lvl(4, 1'b0);
    set_pad(4, 3'd5, 1'b1, 4'd7); tick();
    lvl(4, 1'b1);
    set_pad(4, 3'd7, 1'b0, 4'd7); tick();
    lvl(4, 1'b0);
    rd_chk("R6 codes 0,5,6,7 give no events", A_STAT, 32'h0);
    set_pad(4, 3'd0, 1'b0, 4'd0);

    // R5 level mode, active low with inversion
    pad_level[3] = 1'b1; tick();
    set_pad(3, 3'd4, 1'b1, 4'd3); tick();
    rd_chk("R5 inverted level inactive when high", A_STAT, 32'h0);
    lvl(3, 1'b0);
    rd_chk("R5 inverted level active when low", A_STAT, 32'h0008);
    wr(A_STAT, 32'h0008);
    rd_chk("R5 level re-sets after clear", A_STAT, 32'h0008);
    lvl(3, 1'b1);
    wr(A_STAT, 32'h0008);
    rd_chk("R5 clear sticks once level inactive", A_STAT, 32'h0);
    set_pad(3, 3'd4, 1'b0, 4'd3); tick();
    rd_chk("R5 non-inverted level active high", A_STAT, 32'h0008);
    set_pad(3, 3'd0, 1'b0, 4'd3); tick();
    wr(A_STAT, 32'h0008);

    // R7 two pads on one line, then re-route
    set_pad(0, 3'd2, 1'b0, 4'd9); set_pad(5, 3'd2, 1'b0, 4'd9);
    lvl(0, 1'b0);
    pad_level[0] = 1'b1; pad_level[5] = 1'b1; tick();
    rd_chk("R7 shared line 9 only", A_STAT, 32'h0200);
    wr(A_STAT, 32'h0200);
    set_pad(0, 3'd2, 1'b0, 4'd2);
    lvl(0, 1'b0); lvl(0, 1'b1);
    rd_chk("R7 reselect to line 2", A_STAT, 32'h0004);
    wr(A_STAT, 32'h0004);

    // R9/R10 capture while masked
    wr(A_MASK, 32'h0);
    lvl(0, 1'b0); lvl(0, 1'b1);
    chk("R10 masked line gives no irq", {31'h0, irq_out}, 32'h0);
    rd_chk("R9 captured while masked", A_STAT, 32'h0004);
    wr(A_MASK, 32'h0004);
    chk("R10 enabling pending line raises irq", {31'h0, irq_out}, 32'h1);
    wr(A_MASK, 32'hFFFB);
    chk("R10 other lines enabled only", {31'h0, irq_out}, 32'h0);
    wr(A_STAT, 32'hFFFF);
    wr(A_MASK, 32'hFFFF);

    // R8 event and clear in the same cycle
    lvl(0, 1'b0);
    pad_level[0] = 1'b1; reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0004;
    tick();
    reg_wr = 1'b0;
    rd_chk("R8 event beats same-cycle clear", A_STAT, 32'h0004);
    wr(A_STAT, 32'h0004);

    // R11 other offsets
    rd_chk("R11 unmapped read is zero", 12'h100, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h304, 32'hFFFF);
    rd_chk("R11 unmapped write leaves mask", A_MASK, 32'h0000_FFFF);

    // R12 level held through reset
    set_pad(0, 3'd3, 1'b0, 4'd2);
    pad_level[0] = 1'b1;
    rst = 1'b1; tick(); tick();
    rst = 1'b0; tick();
    wr(A_MASK, 32'hFFFF);
    rd_chk("R12 no edge after reset", A_STAT, 32'h0);

    // random phase
    void'($urandom(32'd2718));
    for (int i = 0; i < 5000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        int p = $urandom_range(0, NP-1);
        set_pad(p, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                4'($urandom_range(0, 15)));
      end
      for (int p = 0; p < NP; p++)
        if ($urandom_range(0, 3) == 0) pad_level[p] = ~pad_level[p];
      reg_wr = ($urandom_range(0, 7) == 0);
      reg_rd = ($urandom_range(0, 1) == 0);
      case ($urandom_range(0, 4))
        0, 1:    reg_addr = A_STAT;
        2, 3:    reg_addr = A_MASK;
        default: reg_addr = 12'($urandom_range(0, 4095));
      endcase
      reg_wdata = $urandom;
      tick();
    end
    reg_wr = 1'b0; reg_rd = 1'b0;
    finish_run();
  end
endmodule